// File: doc/BRIEF.md
# Address-Encoded Write Unlock Sequencer

This block sits behind a read-only memory socket on a host whose address and data share one multiplexed bus. The socket gives the device no write strobe. The host sends bytes by reading from the socket, and the byte rides in the low eight bits of the read address. The block watches the bus on the falling edge of the address latch enable strobe, which is the moment the low bus lines carry address rather than data. It looks only at cycles in which the socket select is active.

Out of reset the block is in state ST_ROM and lets the ROM data path answer reads as usual. When the host makes six qualifying reads in a row whose low address bytes equal the parameterised key, the transition ENTER takes the block to state ST_CMD. In ST_CMD every qualifying read delivers its low address byte on a one-cycle strobe, and the ROM data path is switched off. Returned data leaves on the data bus and incoming bytes arrive on the address lines, so the two directions use separate paths. The block goes back to ST_ROM through transition LEAVE_CODE, when the exit code byte is received, or through LEAVE_REQ, when the return-to-idle input is asserted. Both clear the key match counter.

The strobe is sampled synchronously with the block clock, so that clock must be fast enough to see every high and low phase of the strobe.

Top module: `rom_cmd_unlock`

## Requirements
- R1: After reset the state output `cmd_mode` is 0 (ST_ROM), `rx_valid` is 0 and the key match counter is zero.
- R2: A qualifying read is a clock cycle in which `ale` was 1 in the previous cycle, is 0 now, and `sock_sel` is 1. Cycles without a falling `ale`, and falls while `sock_sel` is 0, change neither the state nor the match counter, and they raise no strobe.
- R3: The byte taken from a qualifying read is the value of `bus_lo` in the cycle of the `ale` fall.
- R4: `rom_oe` follows `sock_sel` while the block is in ST_ROM and is 0 while it is in ST_CMD.
- R5: Six consecutive qualifying reads in ST_ROM carrying KEY bytes 0 to 5 in that order (byte i is KEY[8i+7:8i]) move the block to ST_CMD. `cmd_mode` reads 1 one clock after the sixth fall, and the key reads raise no strobe.
- R6: In ST_ROM, a qualifying read whose byte differs from the next expected key byte restarts the match. The counter becomes 1 if the byte equals key byte 0 and 0 otherwise.
- R7: In ST_CMD, each qualifying read raises `rx_valid` for exactly one clock, one clock after the fall, with `rx_byte` equal to the captured byte.
- R8: In ST_CMD, a qualifying read carrying EXIT_CODE is delivered on the strobe like any other byte, and the block then returns to ST_ROM (`cmd_mode` = 0).
- R9: `exit_req` = 1 at a clock edge puts the block in ST_ROM and clears the match counter. It takes priority over a qualifying read in the same cycle, and that read then produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the latch enable strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| sock_sel | input | 1 | Socket chip select, active high, read cycles only |
| ale | input | 1 | Address latch enable strobe from the host bus |
| bus_lo | input | 8 | Low byte of the multiplexed address/data bus |
| exit_req | input | 1 | Return-to-idle request |
| cmd_mode | output | 1 | Current state: 0 = ST_ROM, 1 = ST_CMD |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Byte received from the host |
| rom_oe | output | 1 | Output enable for the ROM data path |

## Verification
The assertions assume that `ale` stays high for at least one clock between falls, so two qualifying reads can never fall on adjacent clocks. They also assume that `bus_lo` and `sock_sel` are steady in the cycle of the fall. The stimulus meets both: each bus cycle raises `ale` for one full clock, lowers it for at least one, and holds `bus_lo` and `sock_sel` steady from before the rise until after the fall. All inputs change only on falling clock edges.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
    typedef enum logic {
        ST_ROM = 1'b0,
        ST_CMD = 1'b1
    } mode_e;
endpackage

// File: rtl/strobe_fall.sv
module strobe_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/key_seq_match.sv
module key_seq_match #(
    parameter int          KEY_LEN = 6,
    parameter int          BYTE_W  = 8,
    parameter logic [KEY_LEN*BYTE_W-1:0] KEY = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              hit
);
    localparam int CW = $clog2(KEY_LEN + 1);

    logic [BYTE_W-1:0] key_arr [KEY_LEN];
    logic [CW-1:0]     cnt;
    logic              match;

    for (genvar i = 0; i < KEY_LEN; i++) begin : g_key
        assign key_arr[i] = KEY[i*BYTE_W +: BYTE_W];
    end

    assign match = (byte_in == key_arr[cnt]);
    assign hit   = step && match && (cnt == CW'(KEY_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step) begin
            if (hit)                      cnt <= '0;
            else if (match)               cnt <= cnt + 1'b1;
            else if (byte_in == key_arr[0]) cnt <= CW'(1);
            else                          cnt <= '0;
        end
    end
endmodule

// File: rtl/rom_cmd_unlock.sv
module rom_cmd_unlock
    import rcu_pkg::*;
#(
    parameter int          KEY_LEN   = 6,
    parameter int          BYTE_W    = 8,
    parameter logic [KEY_LEN*BYTE_W-1:0] KEY =
        {8'h69, 8'h96, 8'h3C, 8'hC3, 8'h5A, 8'hA5},
    parameter logic [BYTE_W-1:0] EXIT_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sock_sel,
    input  logic              ale,
    input  logic [BYTE_W-1:0] bus_lo,
    input  logic              exit_req,
    output logic              cmd_mode,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rom_oe
);
    mode_e state, state_nx;
    logic  ale_fall;
    logic  qual;
    logic  key_hit;

    strobe_fall u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ale),
        .fall   (ale_fall)
    );

    assign qual = ale_fall && sock_sel;

    key_seq_match #(
        .KEY_LEN (KEY_LEN),
        .BYTE_W  (BYTE_W),
        .KEY     (KEY)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (exit_req),
        .step    (qual && (state == ST_ROM)),
        .byte_in (bus_lo),
        .hit     (key_hit)
    );

    always_comb begin
        state_nx = state;
        if (exit_req) begin
            state_nx = ST_ROM;
        end else begin
            unique case (state)
                ST_ROM:  if (key_hit) state_nx = ST_CMD;
                ST_CMD:  if (qual && bus_lo == EXIT_CODE) state_nx = ST_ROM;
                default: state_nx = ST_ROM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ROM;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= qual && (state == ST_CMD) && !exit_req;
            if (qual && (state == ST_CMD) && !exit_req) rx_byte <= bus_lo;
        end
    end

    assign cmd_mode = (state == ST_CMD);
    assign rom_oe   = sock_sel && (state == ST_ROM);
endmodule

// File: rtl/rom_cmd_unlock_chk.sv
module rom_cmd_unlock_chk #(
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] LAST_KEY = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sock_sel,
    input logic              ale,
    input logic [BYTE_W-1:0] bus_lo,
    input logic              exit_req,
    input logic              cmd_mode,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              rom_oe
);
    logic ale_d;
    logic qual_c;

    always_ff @(posedge clk) begin
        if (!rst_n) ale_d <= 1'b0;
        else        ale_d <= ale;
    end

    assign qual_c = ale_d && !ale && sock_sel;

    AST_OE_OFF_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mode |-> !rom_oe); // R4
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual_c && !exit_req) |=> $stable(cmd_mode)); // R2
    AST_ENTRY_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_mode) |-> ($past(qual_c) && $past(bus_lo) == LAST_KEY)); // R5
    AST_RX_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(qual_c) && rx_byte == $past(bus_lo))); // R3
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_EXIT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (!cmd_mode && !rx_valid)); // R9
endmodule

bind rom_cmd_unlock rom_cmd_unlock_chk #(
    .BYTE_W   (BYTE_W),
    .LAST_KEY (KEY[KEY_LEN*BYTE_W-1 -: BYTE_W])
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sock_sel (sock_sel),
    .ale      (ale),
    .bus_lo   (bus_lo),
    .exit_req (exit_req),
    .cmd_mode (cmd_mode),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rom_oe   (rom_oe)
);

// File: tb/rom_cmd_unlock_tb_top.sv
`timescale 1ns/1ps
module rom_cmd_unlock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sock_sel = 1'b0;
    logic       ale = 1'b0;
    logic [7:0] bus_lo = 8'h00;
    logic       exit_req = 1'b0;
    logic       cmd_mode, rx_valid, rom_oe;
    logic [7:0] rx_byte;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] key [6] = '{8'hA5, 8'h5A, 8'hC3, 8'h3C, 8'h96, 8'h69};
    localparam logic [7:0] EXIT_B = 8'h00;

    always #2.5 clk = ~clk;

    rom_cmd_unlock dut_i (
        .clk(clk), .rst_n(rst_n), .sock_sel(sock_sel), .ale(ale),
        .bus_lo(bus_lo), .exit_req(exit_req), .cmd_mode(cmd_mode),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rom_oe(rom_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle; returns with outputs observed one clock after the ale fall.
    task automatic bus_rd(input logic [7:0] b, input bit sel,
                          output bit rv, output logic [7:0] rb, output bit oe);
        @(negedge clk); sock_sel = sel; bus_lo = b; ale = 1'b1;
        @(negedge clk); oe = rom_oe; ale = 1'b0;
        @(negedge clk); rv = rx_valid; rb = rx_byte;
        sock_sel = 1'b0;
    endtask

    task automatic send_key(input int from);
        bit rv, oe; logic [7:0] rb;
        for (int i = from; i < 6; i++) begin
            bus_rd(key[i], 1'b1, rv, rb, oe);
            chk(!rv, "R5 no strobe on key read", rv, 0);
        end
    endtask

    task automatic do_exit_req();
        @(negedge clk); exit_req = 1'b1;
        @(negedge clk); exit_req = 1'b0;
        chk(!cmd_mode, "R9 exit_req returns to ROM", cmd_mode, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit rv, oe; logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_mode, "R1 reset state", cmd_mode, 0);
        chk(!rx_valid, "R1 reset strobe", rx_valid, 0);
        chk(!rom_oe, "R4 oe idle", rom_oe, 0);

        // Last key byte alone must not unlock: counter clear after reset (R1)
        bus_rd(key[5], 1'b1, rv, rb, oe);
        chk(!cmd_mode, "R1 counter clear after reset", cmd_mode, 0);
        chk(oe, "R4 oe with select in ROM", oe, 1);

        // Full key, with an unselected fall in the middle (R2)
        bus_rd(key[0], 1'b1, rv, rb, oe);
        bus_rd(key[1], 1'b1, rv, rb, oe);
        bus_rd(8'hEE, 1'b0, rv, rb, oe);
        chk(!cmd_mode, "R2 unselected fall ignored", cmd_mode, 0);
        send_key(2);
        chk(cmd_mode, "R5 key enters command", cmd_mode, 1);
        do_exit_req();

        // Key with sock_sel low must not unlock (R2)
        for (int i = 0; i < 6; i++) bus_rd(key[i], 1'b0, rv, rb, oe);
        chk(!cmd_mode, "R2 key without select ignored", cmd_mode, 0);

        // Mismatch at every position with every wrong byte (R6)
        for (int p = 0; p < 6; p++) begin
            for (int w = 0; w < 256; w++) begin
                if (w[7:0] == key[p]) continue;
                for (int i = 0; i < p; i++) bus_rd(key[i], 1'b1, rv, rb, oe);
                bus_rd(w[7:0], 1'b1, rv, rb, oe);
                chk(!cmd_mode, "R6 mismatch stays ROM", cmd_mode, 0);
                send_key((w[7:0] == key[0]) ? 1 : 0);
                chk(cmd_mode, "R6 restart then complete", cmd_mode, 1);
                do_exit_req();
            end
        end

        // exit_req mid-key clears the counter (R9)
        for (int i = 0; i < 3; i++) bus_rd(key[i], 1'b1, rv, rb, oe);
        do_exit_req();
        send_key(3);
        chk(!cmd_mode, "R9 counter cleared by exit_req", cmd_mode, 0);
        do_exit_req();

        // Command state: every byte except the exit code (R3, R7, R4)
        send_key(0);
        for (int b = 0; b < 256; b++) begin
            if (b[7:0] == EXIT_B) continue;
            bus_rd(b[7:0], 1'b1, rv, rb, oe);
            chk(rv, "R7 strobe in command", rv, 1);
            chk(rb == b[7:0], "R3 captured byte", rb, b);
            chk(!oe, "R4 oe off in command", oe, 0);
            @(negedge clk);
            chk(!rx_valid, "R7 strobe one cycle", rx_valid, 0);
            chk(cmd_mode, "R8 stays command", cmd_mode, 1);
        end

        // exit_req together with a qualifying read: no strobe (R9)
        @(negedge clk); sock_sel = 1'b1; bus_lo = 8'h42; ale = 1'b1;
        @(negedge clk); ale = 1'b0; exit_req = 1'b1;
        @(negedge clk); exit_req = 1'b0; sock_sel = 1'b0;
        chk(!rx_valid, "R9 read dropped under exit_req", rx_valid, 0);
        chk(!cmd_mode, "R9 priority over read", cmd_mode, 0);

        // Exit code delivered then ROM state (R8)
        send_key(0);
        bus_rd(EXIT_B, 1'b1, rv, rb, oe);
        chk(rv && rb == EXIT_B, "R8 exit code delivered", rb, EXIT_B);
        chk(!cmd_mode, "R8 exit code returns to ROM", cmd_mode, 0);
        bus_rd(8'h33, 1'b1, rv, rb, oe);
        chk(!rv, "R8 no strobe after exit", rv, 0);
        chk(oe, "R4 oe back in ROM", oe, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule